// File: doc/BRIEF.md
# Eight-Function Combinational ALU

This block is a purely combinational arithmetic-logic unit. It takes two operand words, A and B, and a 3-bit function code. From these it produces one result word. It has no clock, no registers and no status outputs. A new result is available within the same evaluation as any change on its inputs. A surrounding datapath can therefore place it between pipeline registers of its own choosing.

Five of the eight codes are arithmetic: add, increment, subtract, decrement and an unsigned half-width multiply. The low bit of the code swaps operand B for the constant one on the adder and subtractor paths. That bit is what turns add into increment and subtract into decrement. The remaining three codes give a bitwise complement of A, a bitwise exclusive-or of A and B, and a logical left shift of A.

Top module: `eight_op_alu`

## Requirements
- R1: Code 3'b000 gives r = a + b, truncated to 32 bits. It wraps modulo 2^32, with no carry output.
- R2: Code 3'b001 gives r = a + 1. An all-ones a wraps to zero, and b has no effect on the result.
- R3: Code 3'b010 gives r = a - b, truncated to 32 bits. It wraps modulo 2^32, with no borrow output.
- R4: Code 3'b011 gives r = a - 1. A zero a wraps to all-ones, and b has no effect on the result.
- R5: Code 3'b100 gives r = a[15:0] * b[15:0] as a full 32-bit unsigned product. Bits 31:16 of both operands have no effect on the result.
- R6: Code 3'b101 gives r = ~a, and b has no effect on the result.
- R7: Code 3'b110 gives r = a ^ b.
- R8: Code 3'b111 gives r = a shifted left by b[4:0] places, with zeros filled in from bit 0. Bits moved beyond bit 31 are lost, and b[31:5] has no effect on the result.
- R9: For every code and every fully known operand pair, r carries no X or Z bit. It follows input changes with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; b_i[4:0] is the shift count |
| func_i | input | 3 | Function code |
| r_o | output | 32 | Result |

## Verification
Every code is applied to each pairing of the boundary words 0, 1, all-ones, 0x0000FFFF and 0x80000000. These pairings separate correct modular wraparound from a carry or borrow that leaks into the result. They also expose a multiplier that reads the upper operand halves, and a complement that is mistaken for negation. Directed cases set high bits in B under the increment, decrement, complement and shift codes, so the bench can see whether the swapped-in constant and the 5-bit shift count are really what is used. Random operands on all eight codes then catch errors in the code decoding and in mid-word carry chains that the boundary words do not reach.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD = 3'b000,
    FN_INC = 3'b001,
    FN_SUB = 3'b010,
    FN_DEC = 3'b011,
    FN_MUL = 3'b100,
    FN_NOT = 3'b101,
    FN_XOR = 3'b110,
    FN_SHL = 3'b111
  } alu_fn_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              use_one_i,  // swap b for constant 1
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] diff_o
);
  logic [DATA_W-1:0] opnd_b;

  assign opnd_b = use_one_i ? DATA_W'(1) : b_i;
  assign sum_o  = a_i + opnd_b;
  assign diff_o = a_i - opnd_b;
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
  parameter int unsigned HALF_W = 16
) (
  input  logic [HALF_W-1:0]   a_i,
  input  logic [HALF_W-1:0]   b_i,
  output logic [2*HALF_W-1:0] prod_o
);
  logic [2*HALF_W-1:0] a_ext, b_ext;

  assign a_ext  = {{HALF_W{1'b0}}, a_i};
  assign b_ext  = {{HALF_W{1'b0}}, b_i};
  assign prod_o = a_ext * b_ext;
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [DATA_W-1:0]  inv_o,
  output logic [DATA_W-1:0]  xor_o,
  output logic [DATA_W-1:0]  shl_o
);
  assign inv_o = ~a_i;
  assign xor_o = a_i ^ b_i;
  assign shl_o = a_i << shamt_i;
endmodule

// File: rtl/eight_op_alu.sv
module eight_op_alu
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic [DATA_W-1:0] r_o
);
  localparam int unsigned HALF_W  = DATA_W / 2;
  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sum, diff, prod, inv, xr, shl;

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i       (a_i),
    .b_i       (b_i),
    .use_one_i (func_i[0]),
    .sum_o     (sum),
    .diff_o    (diff)
  );

  alu_mul #(.HALF_W(HALF_W)) u_mul (
    .a_i    (a_i[HALF_W-1:0]),
    .b_i    (b_i[HALF_W-1:0]),
    .prod_o (prod)
  );

  alu_logic #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_logic (
    .a_i     (a_i),
    .b_i     (b_i),
    .shamt_i (b_i[SHAMT_W-1:0]),
    .inv_o   (inv),
    .xor_o   (xr),
    .shl_o   (shl)
  );

  always_comb begin
    case (func_i)
      FN_ADD, FN_INC: r_o = sum;
      FN_SUB, FN_DEC: r_o = diff;
      FN_MUL:         r_o = prod;
      FN_NOT:         r_o = inv;
      FN_XOR:         r_o = xr;
      FN_SHL:         r_o = shl;
      default:        r_o = '0;
    endcase
  end
endmodule

// File: rtl/eight_op_alu_chk.sv
module eight_op_alu_chk
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [FUNC_W-1:0] func_i,
  input logic [DATA_W-1:0] r_o
);
  localparam int unsigned HALF_W  = DATA_W / 2;
  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  logic [SHAMT_W-1:0] sh;
  logic [DATA_W-1:0]  low_mask;

  assign sh       = b_i[SHAMT_W-1:0];
  assign low_mask = ~({DATA_W{1'b1}} << sh);

  // Inverse relations: undo the operation and recover a
  always_comb begin
    if (!$isunknown({a_i, b_i, func_i})) begin
      p_known_r9: assert (!$isunknown(r_o)) else $error("r_o unknown");
      if (func_i == FN_ADD)
        p_add_inverse_r1: assert (r_o - b_i == a_i) else $error("add");
      if (func_i == FN_INC)
        p_inc_inverse_r2: assert (r_o - DATA_W'(1) == a_i) else $error("inc");
      if (func_i == FN_SUB)
        p_sub_inverse_r3: assert (r_o + b_i == a_i) else $error("sub");
      if (func_i == FN_DEC)
        p_dec_inverse_r4: assert (r_o + DATA_W'(1) == a_i) else $error("dec");
      if (func_i == FN_MUL && (a_i[HALF_W-1:0] == '0 || b_i[HALF_W-1:0] == '0))
        p_mul_zero_r5: assert (r_o == '0) else $error("mul zero");
      if (func_i == FN_MUL)
        p_mul_lsb_r5: assert (r_o[0] == (a_i[0] & b_i[0])) else $error("mul lsb");
      if (func_i == FN_NOT)
        p_not_disjoint_r6: assert ((r_o ^ a_i) == {DATA_W{1'b1}}) else $error("not");
      if (func_i == FN_XOR)
        p_xor_inverse_r7: assert ((r_o ^ b_i) == a_i) else $error("xor");
      if (func_i == FN_SHL)
        p_shl_zero_fill_r8: assert ((r_o & low_mask) == '0) else $error("shl fill");
      if (func_i == FN_SHL && sh == '0)
        p_shl_identity_r8: assert (r_o == a_i) else $error("shl zero");
    end
  end
endmodule

bind eight_op_alu eight_op_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .func_i (func_i),
  .r_o    (r_o)
);

// File: tb/eight_op_alu_tb.sv
module eight_op_alu_tb;
  localparam int unsigned DW = 32;
  localparam time TCLK = 20ns;

  typedef struct {
    logic [DW-1:0] exp;
    logic [2:0]    fn;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
  } item_t;

  logic          clk = 1'b0;
  logic [DW-1:0] a, b, r;
  logic [2:0]    fn;
  item_t         sb_q[$];
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            done  = 1'b0;

  always #(TCLK/2) clk = ~clk;

  eight_op_alu u_dut (
    .a_i    (a),
    .b_i    (b),
    .func_i (fn),
    .r_o    (r)
  );

  function automatic logic [DW-1:0] ref_model(logic [2:0] f, logic [DW-1:0] x, logic [DW-1:0] y);
    logic [DW-1:0] xl, yl;
    xl = {16'h0, x[15:0]};
    yl = {16'h0, y[15:0]};
    case (f)
      3'd0:    return x + y;
      3'd1:    return x + 32'd1;
      3'd2:    return x - y;
      3'd3:    return x - 32'd1;
      3'd4:    return xl * yl;
      3'd5:    return ~x;
      3'd6:    return x ^ y;
      default: return x << y[4:0];
    endcase
  endfunction

  function automatic string req_of(logic [2:0] f);
    case (f)
      3'd0:    return "R1";
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      3'd4:    return "R5";
      3'd5:    return "R6";
      3'd6:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(logic [2:0] f, logic [DW-1:0] x, logic [DW-1:0] y);
    item_t it;
    @(posedge clk);
    a  = x;
    b  = y;
    fn = f;
    it.exp = ref_model(f, x, y);
    it.fn  = f;
    it.a   = x;
    it.b   = y;
    sb_q.push_back(it);
  endtask

  // Monitor: compare half a period after each drive
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if ($isunknown(r)) begin
        n_bad++;
        $display("FAIL R9 fn=%0d a=%h b=%h actual=%h expected=%h", it.fn, it.a, it.b, r, it.exp);
      end else if (r !== it.exp) begin
        n_bad++;
        $display("FAIL %s fn=%0d a=%h b=%h actual=%h expected=%h",
                 req_of(it.fn), it.fn, it.a, it.b, r, it.exp);
      end
    end
  end

  logic [DW-1:0] edge_v [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h8000_0000};

  initial begin
    a = '0; b = '0; fn = '0;
    // Idle value: all-zero inputs, code 0 (R1, R9)
    drive(3'd0, 32'h0, 32'h0);
    // Boundary grid on every code (R1..R8)
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          drive(3'(f), edge_v[i], edge_v[j]);
    // R2 / R4 wrap, b ignored
    drive(3'd1, 32'hFFFF_FFFF, 32'h1234_5678);
    drive(3'd3, 32'h0, 32'hDEAD_BEEF);
    // R5: upper halves ignored
    drive(3'd4, 32'hABCD_0003, 32'h7777_0005);
    drive(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R6: b ignored
    drive(3'd5, 32'h0F0F_0F0F, 32'hFFFF_FFFF);
    // R8: b[31:5] ignored, full shift range
    drive(3'd7, 32'h8000_0001, 32'hFFFF_FFE3);
    drive(3'd7, 32'hFFFF_FFFF, 32'd31);
    drive(3'd7, 32'h1234_5678, 32'd32);
    // Random operands on all codes
    for (int k = 0; k < 400; k++)
      drive(3'(k % 8), $urandom, $urandom);
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule